// File: doc/BRIEF.md
# DDR4 Command and Address Decoder

This block sits at the receiving end of a DDR4 command/address bus and turns each clock's pin sample into a decoded command record. Two active-low rank selects pick the rank. An active-low activate strobe decides what the three shared command pins mean: when it is low they are the top row-address bits; when it is high they are the normal row-strobe, column-strobe and write-enable lines.

Every field of the record is registered, so the decoded command for the pins sampled at rising edge k can be read after that edge. It stays valid until edge k+1. Fields that do not belong to the decoded command read as zero, so a consumer can use the one-hot command vector together with the fields without any masking of its own. Two cases are reported on flags and not as commands: pin combinations with no assigned meaning, and both ranks selected at the same time.

Top module: `dram_cmd_decode`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every output is zero on the following clock, including the command vector and both flags.
- R2: The pins sampled at a rising edge are decoded into the outputs at that same edge, and the outputs do not change between edges even if the pins do.
- R3: With both rank selects high, the command vector is exactly bit 8 (deselect), the rank index is 0 and all fields are zero.
- R4: With both rank selects low, the conflict flag is 1, the command vector is all zero and every field is zero.
- R5: With exactly one rank select low, the rank index is 0 when select 0 is low and 1 when select 1 is low.
- R6: With one rank selected and the activate strobe low, the command is ACTIVATE (bit 0). The row is {pin16, pin15, pin14, A[13:0]}, taking the low ROW_W bits, and bank group and bank come from their pins.
- R7: With the activate strobe high, the pins {row-strobe, column-strobe, write-enable} select the command: 011 precharge, 001 refresh (bit 5), 000 mode-register set (bit 6), 101 read (bit 1), 100 write (bit 2), 111 no-operation (bit 7). At most one command bit is ever set.
- R8: The patterns 010 and 110 with the activate strobe high set the reserved flag and leave the command vector all zero.
- R9: On read or write, the column is A[9:0], auto-precharge equals A10, and the chop flag equals the inverse of A12 (1 = chopped burst).
- R10: Precharge with A10 low is single-bank (bit 3) and carries the bank group and bank. With A10 high it is all-bank (bit 4), and bank group and bank read zero.
- R11: On a mode-register set, the register index is {BG, BA} and the opcode is {A17, 3'b000, A[13:0]}.
- R12: Row is non-zero only on ACTIVATE. Column, auto-precharge and chop are non-zero only on read or write. Bank group and bank are non-zero only on ACTIVATE, read, write or single-bank precharge. Index and opcode are non-zero only on mode-register set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rank0_sel_n | input | 1 | Rank 0 select, active low |
| rank1_sel_n | input | 1 | Rank 1 select, active low |
| act_strobe_n | input | 1 | Activate strobe, active low |
| pin16_n | input | 1 | Row-strobe, or row bit 16 on activate |
| pin15_n | input | 1 | Column-strobe, or row bit 15 on activate |
| pin14_n | input | 1 | Write-enable, or row bit 14 on activate |
| addr_lo | input | ADDR_LO_W (14) | Address pins A[13:0] |
| addr_hi | input | 1 | Address pin A17 |
| bgrp_in | input | BG_W (2) | Bank group pins |
| bank_in | input | BA_W (2) | Bank pins |
| cmd_o | output | 9 | One-hot command, bit map in R3, R6, R7, R10 |
| rsvd_o | output | 1 | Reserved pin pattern seen |
| cs_err_o | output | 1 | Both ranks selected |
| rank_o | output | 1 | Rank index |
| bgrp_o | output | BG_W (2) | Bank group |
| bank_o | output | BA_W (2) | Bank |
| row_o | output | ROW_W (17) | Row address |
| col_o | output | COL_W (10) | Column address |
| ap_o | output | 1 | Auto-precharge request |
| chop_o | output | 1 | Chopped burst |
| mr_sel_o | output | BG_W+BA_W (4) | Mode-register index |
| mr_op_o | output | ADDR_LO_W+4 (18) | Mode-register opcode |

## Verification
The block holds only one register stage, so a wrong decode shows at the ports on the very next edge. The bench checks each driven pattern at exactly that edge. Faults in the steering of the shared pins show up as a row carrying command bits, a column leaking onto a non-access command, or a wrong bit in the command vector. Several patterns therefore deliberately put non-zero values on pins that the decoded command must ignore. Back-to-back pseudo-random patterns cover stale values carried from one cycle into the next.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
  localparam int CMD_N    = 9;
  localparam int C_ACT    = 0;
  localparam int C_RD     = 1;
  localparam int C_WR     = 2;
  localparam int C_PRE    = 3;
  localparam int C_PREA   = 4;
  localparam int C_REF    = 5;
  localparam int C_MRS    = 6;
  localparam int C_NOP    = 7;
  localparam int C_DES    = 8;
  typedef logic [CMD_N-1:0] cmd_vec_t;

  // {row-strobe, column-strobe, write-enable} with activate strobe high
  localparam logic [2:0] P_PRE = 3'b011;
  localparam logic [2:0] P_REF = 3'b001;
  localparam logic [2:0] P_MRS = 3'b000;
  localparam logic [2:0] P_RD  = 3'b101;
  localparam logic [2:0] P_WR  = 3'b100;
  localparam logic [2:0] P_NOP = 3'b111;
endpackage

// File: rtl/dcd_rank_sel.sv
`timescale 1ns/1ps
module dcd_rank_sel (
  input  logic sel0_n,
  input  logic sel1_n,
  output logic one_sel,
  output logic none_sel,
  output logic both_sel,
  output logic rank
);
  always_comb begin
    none_sel = sel0_n & sel1_n;
    both_sel = ~sel0_n & ~sel1_n;
    one_sel  = sel0_n ^ sel1_n;
    // rank 1 only when select 1 is the single active one
    rank     = one_sel & sel0_n;
  end
endmodule

// File: rtl/dcd_classify.sv
`timescale 1ns/1ps
module dcd_classify
  import dcd_pkg::*;
(
  input  logic     one_sel,
  input  logic     none_sel,
  input  logic     act_n,
  input  logic     p16_n,
  input  logic     p15_n,
  input  logic     p14_n,
  input  logic     a10,
  output cmd_vec_t cmd,
  output logic     rsvd
);
  logic [2:0] pat;
  assign pat = {p16_n, p15_n, p14_n};

  always_comb begin
    cmd  = '0;
    rsvd = 1'b0;
    if (none_sel) begin
      cmd[C_DES] = 1'b1;
    end else if (one_sel) begin
      if (!act_n) begin
        cmd[C_ACT] = 1'b1;
      end else begin
        case (pat)
          P_PRE: begin
            if (a10) cmd[C_PREA] = 1'b1;
            else     cmd[C_PRE]  = 1'b1;
          end
          P_REF:   cmd[C_REF] = 1'b1;
          P_MRS:   cmd[C_MRS] = 1'b1;
          P_RD:    cmd[C_RD]  = 1'b1;
          P_WR:    cmd[C_WR]  = 1'b1;
          P_NOP:   cmd[C_NOP] = 1'b1;
          default: rsvd = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcd_fields.sv
`timescale 1ns/1ps
module dcd_fields #(
  parameter int ADDR_LO_W = 14,
  parameter int ROW_W     = 17,
  parameter int COL_W     = 10,
  parameter int BG_W      = 2,
  parameter int BA_W      = 2,
  localparam int MRS_W    = BG_W + BA_W,
  localparam int OP_W     = ADDR_LO_W + 4
) (
  input  logic                 is_act,
  input  logic                 is_rdwr,
  input  logic                 is_pre1,
  input  logic                 is_mrs,
  input  logic                 p16_n,
  input  logic                 p15_n,
  input  logic                 p14_n,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic                 addr_hi,
  input  logic [BG_W-1:0]      bg,
  input  logic [BA_W-1:0]      ba,
  output logic [BG_W-1:0]      bg_f,
  output logic [BA_W-1:0]      ba_f,
  output logic [ROW_W-1:0]     row_f,
  output logic [COL_W-1:0]     col_f,
  output logic                 ap_f,
  output logic                 chop_f,
  output logic [MRS_W-1:0]     mrs_f,
  output logic [OP_W-1:0]      op_f
);
  logic [ROW_W-1:0] row_raw;
  logic             use_bank;

  generate
    if (ROW_W == ADDR_LO_W + 3) begin : g_row_wide
      assign row_raw = {p16_n, p15_n, p14_n, addr_lo};
    end else begin : g_row_narrow
      assign row_raw = {p15_n, p14_n, addr_lo};
    end
  endgenerate

  assign use_bank = is_act | is_rdwr | is_pre1;

  always_comb begin
    bg_f   = use_bank ? bg : '0;
    ba_f   = use_bank ? ba : '0;
    row_f  = is_act   ? row_raw : '0;
    col_f  = is_rdwr  ? addr_lo[COL_W-1:0] : '0;
    ap_f   = is_rdwr & addr_lo[10];
    chop_f = is_rdwr & ~addr_lo[12];
    mrs_f  = is_mrs   ? {bg, ba} : '0;
    // pins 16..14 are command pins during this command and read as zero
    op_f   = is_mrs   ? {addr_hi, 3'b000, addr_lo} : '0;
  end
endmodule

// File: rtl/dram_cmd_decode.sv
`timescale 1ns/1ps
module dram_cmd_decode
  import dcd_pkg::*;
#(
  parameter int ADDR_LO_W = 14,
  parameter int ROW_W     = 17,
  parameter int COL_W     = 10,
  parameter int BG_W      = 2,
  parameter int BA_W      = 2,
  localparam int MRS_W    = BG_W + BA_W,
  localparam int OP_W     = ADDR_LO_W + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rank0_sel_n,
  input  logic                 rank1_sel_n,
  input  logic                 act_strobe_n,
  input  logic                 pin16_n,
  input  logic                 pin15_n,
  input  logic                 pin14_n,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic                 addr_hi,
  input  logic [BG_W-1:0]      bgrp_in,
  input  logic [BA_W-1:0]      bank_in,
  output logic [CMD_N-1:0]     cmd_o,
  output logic                 rsvd_o,
  output logic                 cs_err_o,
  output logic                 rank_o,
  output logic [BG_W-1:0]      bgrp_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 ap_o,
  output logic                 chop_o,
  output logic [MRS_W-1:0]     mr_sel_o,
  output logic [OP_W-1:0]      mr_op_o
);
  logic             one_sel, none_sel, both_sel, rank_c, rsvd_c;
  cmd_vec_t         cmd_c;
  logic [BG_W-1:0]  bg_c;
  logic [BA_W-1:0]  ba_c;
  logic [ROW_W-1:0] row_c;
  logic [COL_W-1:0] col_c;
  logic             ap_c, chop_c;
  logic [MRS_W-1:0] mrs_c;
  logic [OP_W-1:0]  op_c;

  dcd_rank_sel u_rank (
    .sel0_n   (rank0_sel_n),
    .sel1_n   (rank1_sel_n),
    .one_sel  (one_sel),
    .none_sel (none_sel),
    .both_sel (both_sel),
    .rank     (rank_c)
  );

  dcd_classify u_cls (
    .one_sel  (one_sel),
    .none_sel (none_sel),
    .act_n    (act_strobe_n),
    .p16_n    (pin16_n),
    .p15_n    (pin15_n),
    .p14_n    (pin14_n),
    .a10      (addr_lo[10]),
    .cmd      (cmd_c),
    .rsvd     (rsvd_c)
  );

  dcd_fields #(
    .ADDR_LO_W (ADDR_LO_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .BG_W      (BG_W),
    .BA_W      (BA_W)
  ) u_fld (
    .is_act  (cmd_c[C_ACT]),
    .is_rdwr (cmd_c[C_RD] | cmd_c[C_WR]),
    .is_pre1 (cmd_c[C_PRE]),
    .is_mrs  (cmd_c[C_MRS]),
    .p16_n   (pin16_n),
    .p15_n   (pin15_n),
    .p14_n   (pin14_n),
    .addr_lo (addr_lo),
    .addr_hi (addr_hi),
    .bg      (bgrp_in),
    .ba      (bank_in),
    .bg_f    (bg_c),
    .ba_f    (ba_c),
    .row_f   (row_c),
    .col_f   (col_c),
    .ap_f    (ap_c),
    .chop_f  (chop_c),
    .mrs_f   (mrs_c),
    .op_f    (op_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o    <= '0;
      rsvd_o   <= 1'b0;
      cs_err_o <= 1'b0;
      rank_o   <= 1'b0;
      bgrp_o   <= '0;
      bank_o   <= '0;
      row_o    <= '0;
      col_o    <= '0;
      ap_o     <= 1'b0;
      chop_o   <= 1'b0;
      mr_sel_o <= '0;
      mr_op_o  <= '0;
    end else begin
      cmd_o    <= cmd_c;
      rsvd_o   <= rsvd_c;
      cs_err_o <= both_sel;
      rank_o   <= rank_c;
      bgrp_o   <= bg_c;
      bank_o   <= ba_c;
      row_o    <= row_c;
      col_o    <= col_c;
      ap_o     <= ap_c;
      chop_o   <= chop_c;
      mr_sel_o <= mrs_c;
      mr_op_o  <= op_c;
    end
  end
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker #(
  parameter int ADDR_LO_W = 14,
  parameter int ROW_W     = 17,
  parameter int COL_W     = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rank0_sel_n,
  input logic                 rank1_sel_n,
  input logic                 act_strobe_n,
  input logic                 pin16_n,
  input logic                 pin15_n,
  input logic                 pin14_n,
  input logic [ADDR_LO_W-1:0] addr_lo,
  input logic [8:0]           cmd_o,
  input logic                 rsvd_o,
  input logic                 cs_err_o,
  input logic                 rank_o,
  input logic [ROW_W-1:0]     row_o,
  input logic [COL_W-1:0]     col_o,
  input logic                 ap_o,
  input logic                 chop_o
);
  logic [ADDR_LO_W+2:0] row_pins;
  assign row_pins = {pin16_n, pin15_n, pin14_n, addr_lo};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cmd_o == '0 && !cs_err_o && !rsvd_o));

  p_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    (rank0_sel_n && rank1_sel_n) |=> (cmd_o == 9'h100 && !rank_o));

  p_conflict_r4: assert property (@(posedge clk) disable iff (rst)
    (!rank0_sel_n && !rank1_sel_n) |=> (cs_err_o && cmd_o == '0));

  p_rank_one_r5: assert property (@(posedge clk) disable iff (rst)
    (rank0_sel_n && !rank1_sel_n) |=> rank_o);

  p_act_row_r6: assert property (@(posedge clk) disable iff (rst)
    ((rank0_sel_n != rank1_sel_n) && !act_strobe_n)
      |=> (cmd_o[0] && row_o == $past(row_pins[ROW_W-1:0])));

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_o));

  p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    ((rank0_sel_n != rank1_sel_n) && act_strobe_n && !pin15_n == 1'b0 && pin14_n == 1'b0 && pin15_n)
      |=> (rsvd_o && cmd_o == '0));

  p_access_only_r12: assert property (@(posedge clk) disable iff (rst)
    !(cmd_o[1] || cmd_o[2]) |-> (!ap_o && !chop_o && col_o == '0));
endmodule

bind dram_cmd_decode dcd_checker #(
  .ADDR_LO_W (ADDR_LO_W),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rank0_sel_n  (rank0_sel_n),
  .rank1_sel_n  (rank1_sel_n),
  .act_strobe_n (act_strobe_n),
  .pin16_n      (pin16_n),
  .pin15_n      (pin15_n),
  .pin14_n      (pin14_n),
  .addr_lo      (addr_lo),
  .cmd_o        (cmd_o),
  .rsvd_o       (rsvd_o),
  .cs_err_o     (cs_err_o),
  .rank_o       (rank_o),
  .row_o        (row_o),
  .col_o        (col_o),
  .ap_o         (ap_o),
  .chop_o       (chop_o)
);

// File: tb/sim_dram_cmd_decode.sv
`timescale 1ns/1ps
module sim_dram_cmd_decode;
  typedef struct packed {
    logic [8:0]  cmd;
    logic        rsvd;
    logic        err;
    logic        rank;
    logic [1:0]  bg;
    logic [1:0]  ba;
    logic [16:0] row;
    logic [9:0]  col;
    logic        ap;
    logic        chop;
    logic [3:0]  mrs;
    logic [17:0] op;
  } rec_t;

  typedef struct {
    rec_t  r;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s0 = 1'b1, s1 = 1'b1, actn = 1'b1;
  logic        p16 = 1'b1, p15 = 1'b1, p14 = 1'b1;
  logic [13:0] alo = '0;
  logic        ahi = 1'b0;
  logic [1:0]  bg = '0, ba = '0;

  logic [8:0]  cmd_o;
  logic        rsvd_o, cs_err_o, rank_o, ap_o, chop_o;
  logic [1:0]  bgrp_o, bank_o;
  logic [16:0] row_o;
  logic [9:0]  col_o;
  logic [3:0]  mr_sel_o;
  logic [17:0] mr_op_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  item_t q[$];

  always #4 clk = ~clk;

  dram_cmd_decode u0 (
    .clk(clk), .rst(rst), .rank0_sel_n(s0), .rank1_sel_n(s1),
    .act_strobe_n(actn), .pin16_n(p16), .pin15_n(p15), .pin14_n(p14),
    .addr_lo(alo), .addr_hi(ahi), .bgrp_in(bg), .bank_in(ba),
    .cmd_o(cmd_o), .rsvd_o(rsvd_o), .cs_err_o(cs_err_o), .rank_o(rank_o),
    .bgrp_o(bgrp_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .ap_o(ap_o), .chop_o(chop_o), .mr_sel_o(mr_sel_o), .mr_op_o(mr_op_o)
  );

  function automatic rec_t actual();
    rec_t a;
    a = '{cmd_o, rsvd_o, cs_err_o, rank_o, bgrp_o, bank_o, row_o, col_o,
          ap_o, chop_o, mr_sel_o, mr_op_o};
    return a;
  endfunction

  // Expected record from the requirement text
  function automatic rec_t model(logic c0, logic c1, logic an, logic r,
                                 logic c, logic w, logic [13:0] a,
                                 logic ah, logic [1:0] g, logic [1:0] b);
    rec_t e = '0;
    if (!c0 && !c1) e.err = 1'b1;                    // R4
    else if (c0 && c1) e.cmd[8] = 1'b1;              // R3
    else begin
      e.rank = c0;                                   // R5
      if (!an) begin                                 // R6
        e.cmd[0] = 1'b1; e.row = {r, c, w, a}; e.bg = g; e.ba = b;
      end else begin
        case ({r, c, w})
          3'b011: if (a[10]) e.cmd[4] = 1'b1;        // R10
                  else begin e.cmd[3] = 1'b1; e.bg = g; e.ba = b; end
          3'b001: e.cmd[5] = 1'b1;
          3'b000: begin e.cmd[6] = 1'b1; e.mrs = {g, b};     // R11
                        e.op = {ah, 3'b000, a}; end
          3'b101, 3'b100: begin                      // R9
            if (w) e.cmd[1] = 1'b1; else e.cmd[2] = 1'b1;
            e.col = a[9:0]; e.ap = a[10]; e.chop = ~a[12];
            e.bg = g; e.ba = b;
          end
          3'b111: e.cmd[7] = 1'b1;
          default: e.rsvd = 1'b1;                    // R8
        endcase
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input rec_t act, input rec_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c0, input logic c1, input logic an,
                       input logic [2:0] rcw, input logic [13:0] a,
                       input logic ah, input logic [1:0] g, input logic [1:0] b,
                       input string tag);
    item_t it;
    @(negedge clk);
    s0 = c0; s1 = c1; actn = an; {p16, p15, p14} = rcw;
    alo = a; ahi = ah; bg = g; ba = b;
    it.r = model(c0, c1, an, rcw[2], rcw[1], rcw[0], a, ah, g, b);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        rec_t  a;
        it = q.pop_front();
        a = actual();
        check(a == it.r, it.tag, a, it.r);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R1: reset state with active-looking pins held
    s0 = 1'b0; actn = 1'b0; alo = 14'h3fff; bg = 2'b11;
    @(negedge clk);
    check(actual() == '0, "R1 reset state", actual(), '0);
    rst = 1'b0;

    drive(1, 1, 0, 3'b000, 14'h1234, 1, 2'b10, 2'b01, "R3 deselect");
    drive(0, 0, 0, 3'b101, 14'h2aaa, 1, 2'b11, 2'b11, "R4 both ranks");
    drive(0, 0, 1, 3'b000, 14'h0fff, 1, 2'b01, 2'b10, "R4 both ranks mrs pins");
    drive(0, 1, 0, 3'b101, 14'h3c5a, 0, 2'b01, 2'b10, "R6 activate rank0 R5");
    drive(1, 0, 0, 3'b010, 14'h0001, 1, 2'b10, 2'b11, "R6 activate rank1 R5");
    drive(0, 1, 1, 3'b101, 14'h0723, 1, 2'b11, 2'b00, "R9 read ap chop");
    drive(1, 0, 1, 3'b100, 14'h1b0f, 0, 2'b00, 2'b11, "R9 write full burst");
    drive(0, 1, 1, 3'b011, 14'h0000, 0, 2'b10, 2'b01, "R10 precharge one");
    drive(1, 0, 1, 3'b011, 14'h0400, 0, 2'b11, 2'b10, "R10 precharge all");
    drive(0, 1, 1, 3'b001, 14'h3fff, 1, 2'b11, 2'b11, "R7 refresh R12");
    drive(1, 0, 1, 3'b111, 14'h2fff, 1, 2'b01, 2'b01, "R7 nop R12");
    drive(0, 1, 1, 3'b000, 14'h2d3c, 1, 2'b10, 2'b11, "R11 mode register");
    drive(0, 1, 1, 3'b010, 14'h0555, 0, 2'b01, 2'b01, "R8 reserved 010");
    drive(1, 0, 1, 3'b110, 14'h0aaa, 1, 2'b10, 2'b10, "R8 reserved 110");

    // R2: outputs hold while pins change between edges
    drive(0, 1, 0, 3'b111, 14'h1111, 0, 2'b01, 2'b00, "R2 activate before hold");
    @(posedge clk);
    #3;
    s0 = 1'b1; s1 = 1'b0; actn = 1'b1; {p16, p15, p14} = 3'b100;
    #0;
    begin
      rec_t e;
      e = model(0, 1, 0, 1, 1, 1, 14'h1111, 0, 2'b01, 2'b00);
      check(actual() == e, "R2 hold between edges", actual(), e);
    end

    // Back-to-back pseudo-random patterns
    lf = 32'h1ace_b00c;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[0], lf[1] | lf[9], lf[2] | lf[3], lf[6:4], lf[20:7], lf[21],
            lf[23:22], lf[25:24], "R7 sequence R12");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule